// File: doc/BRIEF.md
# NAND Boot Page Download Controller

This block sits on the host side of a NAND memory that loads its first page into its page buffer by itself at power-up. It copies that page into a local buffer without issuing any command or address cycles. After reset it keeps chip enable low and read enable high. It waits until the ready/busy line, passed through a two-flop synchronizer, reports ready. It then strobes the active-low read enable once per byte and samples the 8-bit I/O bus on the last cycle of each low phase. Each sampled byte goes out on a simple write port: address, data and a one-cycle strobe.

When the last byte of the page has been sampled, the controller takes chip enable high. This stops a device that would otherwise carry on into the following pages. One cycle later it raises a sticky done flag. If the device stays busy for too long, the controller gives up instead. It raises a sticky error flag, releases chip enable and issues no reads.

Top module: `nand_boot_fetch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, nand_ce_n is 0, nand_re_n is 1, and buf_we, done and timeout_err are all 0. The block has no command-latch or address-latch outputs.
- R2: nand_rb reaches the control logic through two flops. After nand_rb rises, nand_re_n stays 1 for two more clock cycles and first goes 0 in the third cycle.
- R3: Each byte is read by holding nand_re_n at 0 for LOW_CYC cycles (default 2) and then at 1 for HIGH_CYC cycles (default 2). nand_io is captured on the last low cycle.
- R4: Each capture produces buf_we = 1 for exactly the following cycle. During that cycle, buf_wdata holds the captured byte and buf_addr holds the byte index, which counts 0, 1, … up to PAGE_BYTES-1 (default 527).
- R5: The cycle in which the byte at index PAGE_BYTES-1 is written has nand_ce_n = 1 and nand_re_n = 1. No further read-enable pulses follow.
- R6: done goes to 1 one cycle after the final write and holds until reset. Once done is 1, nand_rb and nand_io have no effect: there are no writes and no nand_re_n pulses.
- R7: If the synchronized ready/busy stays 0 for more than TIMEOUT_CYC cycles (default 65535) while waiting, timeout_err goes to 1 and holds. nand_ce_n then goes to 1 and no read or write occurs.
- R8: Once the first read has begun, nand_rb is ignored. A busy pulse in the middle of a page neither pauses nor restarts the download.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nand_rb | input | 1 | Ready/busy from the memory, 1 = ready (asynchronous) |
| nand_io | input | 8 | Data bus from the memory |
| nand_ce_n | output | 1 | Active-low chip enable |
| nand_re_n | output | 1 | Active-low read enable |
| buf_we | output | 1 | Buffer write strobe, one cycle per byte |
| buf_addr | output | 10 | Buffer write address (byte index) |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | Page copied, sticky until reset |
| timeout_err | output | 1 | Ready never seen within the limit, sticky until reset |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the memory keeps nand_io unchanged from the falling edge of nand_re_n until its rising edge. The bench acts as that memory. It moves the bus to the next byte only on the clock cycle after nand_re_n has gone back high, and it changes nand_rb only at the falling clock edge. It then drives ready/busy freely, including a busy pulse in the middle of a page and a line that never becomes ready. This shows that those inputs have no effect once the transfer has started or finished.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_LOW  = 3'd1,
    ST_HIGH = 3'd2,
    ST_FIN  = 3'd3,
    ST_DONE = 3'd4,
    ST_ERR  = 3'd5
  } nbf_state_e;

  // True on the final cycle of a phase that lasts len cycles.
  function automatic logic phase_last(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) == len;
  endfunction

  // Chip enable is released once the page is finished or the wait failed.
  function automatic logic ce_released(input nbf_state_e s);
    return (s == ST_FIN) || (s == ST_DONE) || (s == ST_ERR);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nbf_sync2.sv
module nbf_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nbf_seq.sv
module nbf_seq
  import nbf_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 528,
  parameter int unsigned LOW_CYC     = 2,
  parameter int unsigned HIGH_CYC    = 2,
  parameter int unsigned TIMEOUT_CYC = 65535,
  parameter int unsigned ADDR_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_s,
  output nbf_state_e        state,
  output logic              sample_evt,
  output logic [ADDR_W-1:0] byte_idx
);
  localparam int unsigned PH_W = $clog2(max2(LOW_CYC, HIGH_CYC) + 1);
  localparam int unsigned TO_W = $clog2(TIMEOUT_CYC + 1);

  logic [PH_W-1:0] ph;
  logic [TO_W-1:0] wait_cnt;
  logic low_end, high_end, at_last;

  assign low_end    = phase_last(32'(ph), LOW_CYC);
  assign high_end   = phase_last(32'(ph), HIGH_CYC);
  assign at_last    = (byte_idx == ADDR_W'(PAGE_BYTES - 1));
  assign sample_evt = (state == ST_LOW) && low_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_WAIT;
      ph       <= '0;
      wait_cnt <= '0;
      byte_idx <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (rb_s) begin
            state <= ST_LOW;
            ph    <= '0;
          end else if (wait_cnt == TO_W'(TIMEOUT_CYC)) begin
            state <= ST_ERR;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (low_end) begin
            ph    <= '0;
            state <= at_last ? ST_FIN : ST_HIGH;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_HIGH: begin
          if (high_end) begin
            ph       <= '0;
            byte_idx <= byte_idx + 1'b1;
            state    <= ST_LOW;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_FIN:  state <= ST_DONE;
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/nbf_capture.sv
module nbf_capture #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_evt,
  input  logic [ADDR_W-1:0] byte_idx,
  input  logic [DATA_W-1:0] io_in,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else begin
      we <= sample_evt;
      if (sample_evt) begin
        addr  <= byte_idx;
        wdata <= io_in;
      end
    end
  end
endmodule

// File: rtl/nand_boot_fetch.sv
module nand_boot_fetch
  import nbf_pkg::*;
#(
  parameter  int unsigned PAGE_BYTES  = 528,
  parameter  int unsigned LOW_CYC     = 2,
  parameter  int unsigned HIGH_CYC    = 2,
  parameter  int unsigned TIMEOUT_CYC = 65535,
  parameter  int unsigned DATA_W      = 8,
  localparam int unsigned ADDR_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nand_rb,
  input  logic [DATA_W-1:0] nand_io,
  output logic              nand_ce_n,
  output logic              nand_re_n,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              done,
  output logic              timeout_err
);
  nbf_state_e        state;
  logic              rb_s;
  logic              sample_evt;
  logic              in_wait;
  logic [ADDR_W-1:0] byte_idx;

  nbf_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_s)
  );

  nbf_seq #(
    .PAGE_BYTES(PAGE_BYTES), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .rb_s(rb_s),
    .state(state), .sample_evt(sample_evt), .byte_idx(byte_idx)
  );

  nbf_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .byte_idx(byte_idx),
    .io_in(nand_io), .we(buf_we), .addr(buf_addr), .wdata(buf_wdata)
  );

  assign in_wait     = (state == ST_WAIT);
  assign nand_re_n   = (state != ST_LOW);
  assign nand_ce_n   = ce_released(state);
  assign done        = (state == ST_DONE);
  assign timeout_err = (state == ST_ERR);
endmodule

// File: rtl/nbf_checker.sv
module nbf_checker #(
  parameter int unsigned PAGE_BYTES = 528,
  parameter int unsigned ADDR_W     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nand_re_n,
  input logic              nand_ce_n,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              done,
  input logic              timeout_err,
  input logic              in_wait,
  input logic              sample_evt
);
  // R2: no read strobe while still waiting for ready
  a_r2_no_read_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> nand_re_n);

  // R4: a capture is followed by exactly one write strobe
  a_r4_we_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> buf_we);
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> !buf_we);
  a_r4_addr_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_addr <= ADDR_W'(PAGE_BYTES - 1)));

  // R5: the final write comes with chip enable released
  a_r5_ce_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && buf_addr == ADDR_W'(PAGE_BYTES - 1)) |-> (nand_ce_n && nand_re_n));

  // R6: done is sticky and quiet
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nand_re_n && nand_ce_n && !buf_we));

  // R7: error is sticky, exclusive of done, and releases the device
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  a_r7_err_released: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (nand_ce_n && nand_re_n && !done));
endmodule

bind nand_boot_fetch nbf_checker #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
  .buf_we(buf_we), .buf_addr(buf_addr), .done(done), .timeout_err(timeout_err),
  .in_wait(in_wait), .sample_evt(sample_evt)
);

// File: tb/tb_nand_boot_fetch.sv
`timescale 1ns/1ps
module tb_nand_boot_fetch;
  localparam int PAGE = 528;
  localparam int LOWC = 2;
  localparam int HIGHC = 2;
  localparam int TO = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nand_rb = 1'b0;
  logic [7:0] nand_io = 8'h00;
  logic nand_ce_n, nand_re_n, buf_we, done, timeout_err;
  logic [9:0] buf_addr;
  logic [7:0] buf_wdata;

  always #4 clk = ~clk;

  nand_boot_fetch dut (
    .clk(clk), .rst_n(rst_n), .nand_rb(nand_rb), .nand_io(nand_io),
    .nand_ce_n(nand_ce_n), .nand_re_n(nand_re_n), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .done(done), .timeout_err(timeout_err)
  );

  int checks = 0;
  int errors = 0;
  int seed = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int s);
    return 8'((k * 7 + s + (k >> 8)) & 255);
  endfunction

  // ---------------- behavioural reference model (updated at posedge) ----------
  // phase codes: 0 wait, 1 read-low, 2 read-high, 3 finishing, 4 done, 5 error
  int m_phase, m_ph, m_wc, m_idx;
  bit m_s1, m_s2, m_we;
  int m_addr, m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ph = 0; m_wc = 0; m_idx = 0;
      m_s1 = 0; m_s2 = 0; m_we = 0; m_addr = 0; m_data = 0;
    end else begin
      m_we = 0;
      case (m_phase)
        0: if (m_s2) begin m_phase = 1; m_ph = 0; end
           else if (m_wc == TO) m_phase = 5;
           else m_wc++;
        1: if (m_ph == LOWC - 1) begin
             m_we = 1; m_addr = m_idx; m_data = int'(nand_io);
             m_ph = 0;
             m_phase = (m_idx == PAGE - 1) ? 3 : 2;
           end else m_ph++;
        2: if (m_ph == HIGHC - 1) begin m_ph = 0; m_idx++; m_phase = 1; end
           else m_ph++;
        3: m_phase = 4;
        default: ;
      endcase
      m_s2 = m_s1;
      m_s1 = nand_rb;
    end
  end

  // ---------------- memory model, scoreboard and per-cycle compare (negedge) --
  bit prev_re = 1;
  int k_rd = 0;
  int wr_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_re = 1; k_rd = 0; wr_cnt = 0;
    end else begin
      chk(nand_re_n == (m_phase != 1), "R3", "re_n", int'(nand_re_n), int'(m_phase != 1));
      chk(nand_ce_n == (m_phase >= 3), "R5", "ce_n", int'(nand_ce_n), int'(m_phase >= 3));
      chk(done == (m_phase == 4), "R6", "done", int'(done), int'(m_phase == 4));
      chk(timeout_err == (m_phase == 5), "R7", "timeout_err", int'(timeout_err), int'(m_phase == 5));
      chk(buf_we == m_we, "R4", "buf_we", int'(buf_we), int'(m_we));
      if (buf_we) begin
        chk(int'(buf_addr) == wr_cnt, "R4", "buf_addr order", int'(buf_addr), wr_cnt);
        chk(buf_wdata == pat(int'(buf_addr), seed), "R3", "captured byte",
            int'(buf_wdata), int'(pat(int'(buf_addr), seed)));
        chk(int'(buf_addr) == m_addr && int'(buf_wdata) == m_data, "R4", "write vs model",
            int'(buf_addr), m_addr);
        wr_cnt++;
      end
      if (!prev_re && nand_re_n) k_rd++;
      prev_re = nand_re_n;
      nand_io = pat(k_rd, seed);
    end
    if (cyc > 195000 && !finished) begin
      chk(0, "WDOG", "watchdog expired", cyc, 195000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset(input int s, input bit rb0);
    @(negedge clk);
    rst_n = 0; seed = s; nand_rb = rb0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(nand_ce_n == 0 && nand_re_n == 1, "R1", "ce_n/re_n in reset", {nand_ce_n, nand_re_n}, 1);
    chk(!buf_we && !done && !timeout_err, "R1", "flags in reset", {buf_we, done, timeout_err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(nand_ce_n == 0 && nand_re_n == 1 && !done, "R1", "first cycle after reset",
        {nand_ce_n, nand_re_n, done}, 1);
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) @(negedge clk);
  endtask

  task automatic after_done_quiet();
    int w0 = wr_cnt;
    for (int i = 0; i < 40; i++) begin
      nand_rb = i[2];
      @(negedge clk);
    end
    chk(wr_cnt == w0, "R6", "no writes after done", wr_cnt, w0);
    chk(done == 1, "R6", "done held", int'(done), 1);
  endtask

  initial begin
    // Case 1: busy for a while, then ready
    do_reset(11, 1'b0);
    repeat (20) @(negedge clk);
    nand_rb = 1;
    @(negedge clk);
    chk(nand_re_n == 1, "R2", "re_n one cycle after ready", int'(nand_re_n), 1);
    @(negedge clk);
    chk(nand_re_n == 1, "R2", "re_n two cycles after ready", int'(nand_re_n), 1);
    @(negedge clk);
    chk(nand_re_n == 0, "R2", "first read strobe", int'(nand_re_n), 0);
    wait_done(PAGE * (LOWC + HIGHC) + 50);
    chk(wr_cnt == PAGE, "R4", "bytes written", wr_cnt, PAGE);
    chk(done && nand_ce_n, "R5", "ce released at done", {done, nand_ce_n}, 3);
    after_done_quiet();

    // Case 2: ready already high at reset, busy pulse mid-page (R8)
    do_reset(77, 1'b1);
    repeat (300) @(negedge clk);
    nand_rb = 0;
    repeat (30) @(negedge clk);
    chk(!nand_re_n || wr_cnt > 0, "R8", "transfer running during busy pulse", wr_cnt, 1);
    nand_rb = 1;
    wait_done(PAGE * (LOWC + HIGHC) + 50);
    chk(wr_cnt == PAGE, "R8", "full page despite busy pulse", wr_cnt, PAGE);
    chk(done == 1, "R6", "done after case 2", int'(done), 1);
    after_done_quiet();

    // Case 3: never ready -> timeout
    do_reset(5, 1'b0);
    repeat (TO - 10) @(negedge clk);
    chk(timeout_err == 0, "R7", "no error before limit", int'(timeout_err), 0);
    repeat (30) @(negedge clk);
    chk(timeout_err == 1, "R7", "error after limit", int'(timeout_err), 1);
    chk(nand_ce_n == 1 && wr_cnt == 0, "R7", "released, nothing read", wr_cnt, 0);
    nand_rb = 1;
    repeat (10) @(negedge clk);
    chk(timeout_err == 1 && nand_re_n == 1, "R7", "error sticky", int'(timeout_err), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule